// File: doc/BRIEF.md
# Floating-Point Status Register with Sticky Exceptions

This block holds the 32-bit status and control word of a floating-point unit. The word carries a fixed identifier that marks a hardware implementation, a byte of per-exception trap enables, five mode-control bits and five sticky cumulative exception flags. Software writes and reads the word through a plain register port. The arithmetic datapath reports each result through an exception-report input. That input carries five raw exception events and two qualifiers for underflow: tininess and loss of accuracy.

For every reported exception the block chooses one of two outcomes. It either sets the matching sticky flag or raises a trap request, and never both. The trap enable that belongs to the exception makes the choice. Underflow is judged by a different rule depending on its own enable. A trapped overflow or underflow suppresses inexact. The trap request is a registered status pulse that names the causes. The exception report is a single-cycle event with no back-pressure: `exc_valid` is sampled on every clock edge, and the block is always ready to take it. The stored fields are not touched by reset.

Top module: `fpsr_unit`

## Requirements
- R1: `sw_rd_data[31:24]` always reads 0x81, and no software write can change it.
- R2: The reserved bits 23:21, 15:13 and 7:5 always read zero, even after a write of ones to them.
- R3: A write with `sw_wr_en` high stores bits 20:16 (trap enables), 12:8 (control) and 4:0 (flags). `sw_rd_data` returns the stored values from the cycle after the write edge.
- R4: While `rst_n` is low, `trap_req` and `trap_cause` are zero. Reset leaves the enable, control and flag fields unchanged.
- R5: Flags and enables use one bit encoding: bit 4 inexact, 3 underflow, 2 overflow, 1 divide by zero, 0 invalid. Enables use the same encoding offset by 16. A qualified exception whose enable is clear sets its flag. One whose enable is set instead drives the matching `trap_cause` bit and `trap_req` high for the cycle after the report edge, and leaves its flag unchanged.
- R6: Flags are sticky. Exception reports never clear them, and idle cycles never clear them. Only a software write can clear a flag.
- R7: With the underflow enable set, an underflow event with `exc_tiny` high is a qualified underflow, whatever the value of `exc_acc_loss`.
- R8: With the underflow enable clear, an underflow event needs both `exc_tiny` and `exc_acc_loss` to qualify. A qualified underflow in this case also raises inexact.
- R9: A qualified overflow with the overflow enable clear also raises inexact.
- R10: When overflow or underflow is trapped in a report, inexact from that same report is dropped entirely: it sets no flag and raises no trap.
- R11: If a write and a report share an edge, the flags set by hardware are ORed onto the written flag value. The flag-or-trap choice uses the enables held before that edge.
- R12: When `exc_valid` is low, the event and qualifier inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the trap outputs only |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| sw_rd_data | output | 32 | Current register word |
| exc_valid | input | 1 | Exception report present this cycle |
| exc_event | input | 5 | Raw events (4 IX, 3 UF, 2 OF, 1 DZ, 0 IO) |
| exc_tiny | input | 1 | Underflow qualifier: the result is tiny |
| exc_acc_loss | input | 1 | Underflow qualifier: denormalization lost accuracy |
| trap_req | output | 1 | At least one exception trapped in the last report |
| trap_cause | output | 5 | Trapped exceptions, same encoding as the flags |

## Verification
The bench targets the underflow rule under both enable settings. A design that ignored the enable would flag a tiny result that lost no accuracy, or would fail to trap a tiny result that was exact. It checks the overflow and underflow precedence over inexact. A wrong design would raise an inexact trap, or set an inexact flag, next to a trapped overflow. It drives a write and a report on the same edge. A design that let the write win would lose the hardware flag, and one that decided with the newly written enables would trap where it should have flagged. Reset is pulsed between a write and a read, which exposes a design that clears the fields on reset.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EXC_N    = 5;
  localparam int unsigned CTRL_W   = 5;
  localparam int unsigned ID_W     = 8;
  localparam int unsigned ID_LSB   = 24;
  localparam int unsigned EN_LSB   = 16;
  localparam int unsigned CTRL_LSB = 8;
  localparam int unsigned FLAG_LSB = 0;

  localparam int unsigned X_IO = 0;
  localparam int unsigned X_DZ = 1;
  localparam int unsigned X_OF = 2;
  localparam int unsigned X_UF = 3;
  localparam int unsigned X_IX = 4;

  typedef logic [EXC_N-1:0]  exc_vec_t;
  typedef logic [CTRL_W-1:0] ctrl_vec_t;
endpackage

// File: rtl/fpsr_exc_resolve.sv
module fpsr_exc_resolve
  import fpsr_pkg::*;
(
  input  exc_vec_t ev,
  input  logic     tiny,
  input  logic     acc_loss,
  input  exc_vec_t trap_en,
  output exc_vec_t set_mask,
  output exc_vec_t trap_mask
);
  logic     uf_q, of_q, ix_raw, ix_kill;
  exc_vec_t eff;

  always_comb begin
    uf_q    = ev[X_UF] & tiny & (trap_en[X_UF] | acc_loss);
    of_q    = ev[X_OF];
    ix_raw  = ev[X_IX] | (of_q & ~trap_en[X_OF]) | (uf_q & ~trap_en[X_UF]);
    ix_kill = (of_q & trap_en[X_OF]) | (uf_q & trap_en[X_UF]);
    eff       = ev;
    eff[X_UF] = uf_q;
    eff[X_OF] = of_q;
    eff[X_IX] = ix_raw & ~ix_kill;
  end

  for (genvar i = 0; i < EXC_N; i++) begin : g_bit
    assign set_mask[i]  = eff[i] & ~trap_en[i];
    assign trap_mask[i] = eff[i] &  trap_en[i];
  end

  always_comb begin
    p_flag_or_trap_r5: assert ((set_mask & trap_mask) == '0)
      else $error("exception both flagged and trapped");
    p_ix_precedence_r10: assert (!(trap_mask[X_IX] && (trap_mask[X_OF] || trap_mask[X_UF])))
      else $error("inexact trap beside overflow/underflow trap");
  end
endmodule

// File: rtl/fpsr_store.sv
module fpsr_store
  import fpsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  exc_vec_t wr_en_field,
  input  ctrl_vec_t wr_ctrl_field,
  input  exc_vec_t wr_flag_field,
  input  exc_vec_t hw_set,
  output exc_vec_t en_q,
  output ctrl_vec_t ctrl_q,
  output exc_vec_t flag_q
);
  always_ff @(posedge clk) begin
    if (wr_en) begin
      en_q   <= wr_en_field;
      ctrl_q <= wr_ctrl_field;
      flag_q <= wr_flag_field | hw_set;
    end else begin
      flag_q <= flag_q | hw_set;
    end
  end

  p_flags_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (($past(flag_q) & ~flag_q) == '0))
    else $error("flag cleared without write");

  p_hw_set_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_set) != '0 |-> (($past(hw_set) & ~flag_q) == '0))
    else $error("hardware flag set lost");
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter logic [7:0] SYS_ID = 8'h81
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [31:0] sw_wr_data,
  output logic [31:0] sw_rd_data,
  input  logic        exc_valid,
  input  logic [4:0]  exc_event,
  input  logic        exc_tiny,
  input  logic        exc_acc_loss,
  output logic        trap_req,
  output logic [4:0]  trap_cause
);
  exc_vec_t  en_q, flag_q, set_mask, trap_mask, ev_gated, hw_set;
  ctrl_vec_t ctrl_q;

  assign ev_gated = exc_valid ? exc_event : '0;

  fpsr_exc_resolve u_resolve (
    .ev        (ev_gated),
    .tiny      (exc_tiny),
    .acc_loss  (exc_acc_loss),
    .trap_en   (en_q),
    .set_mask  (set_mask),
    .trap_mask (trap_mask)
  );

  assign hw_set = set_mask;

  fpsr_store u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (sw_wr_en),
    .wr_en_field   (sw_wr_data[EN_LSB +: EXC_N]),
    .wr_ctrl_field (sw_wr_data[CTRL_LSB +: CTRL_W]),
    .wr_flag_field (sw_wr_data[FLAG_LSB +: EXC_N]),
    .hw_set        (hw_set),
    .en_q          (en_q),
    .ctrl_q        (ctrl_q),
    .flag_q        (flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= |trap_mask;
      trap_cause <= trap_mask;
    end
  end

  always_comb begin
    sw_rd_data = '0;
    sw_rd_data[ID_LSB +: ID_W]     = SYS_ID;
    sw_rd_data[EN_LSB +: EXC_N]    = en_q;
    sw_rd_data[CTRL_LSB +: CTRL_W] = ctrl_q;
    sw_rd_data[FLAG_LSB +: EXC_N]  = flag_q;
  end

  p_trap_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((trap_cause & ~$past(en_q)) == '0))
    else $error("trap without enable");

  p_trap_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (trap_cause != '0))
    else $error("trap_req disagrees with cause");

  p_idle_no_trap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> (trap_cause == '0))
    else $error("trap without valid report");
endmodule

// File: tb/sim_fpsr_unit.sv
module sim_fpsr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] sw_rd_data;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_event = '0;
  logic        exc_tiny = 1'b0;
  logic        exc_acc_loss = 1'b0;
  logic        trap_req;
  logic [4:0]  trap_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0] m_en, m_ctrl, m_flag, m_trap;

  always #10 clk = ~clk;

  fpsr_unit u0 (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .exc_valid(exc_valid), .exc_event(exc_event),
    .exc_tiny(exc_tiny), .exc_acc_loss(exc_acc_loss),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  // Returns {trap, set} from the requirement rules R5, R7-R10.
  function automatic logic [9:0] expect_split(input logic [4:0] en, input logic [4:0] ev,
                                              input logic t, input logic l);
    logic uf, of, ix;
    logic [4:0] e;
    uf = ev[3] && t && (en[3] || l);
    of = ev[2];
    ix = ev[4] || (of && !en[2]) || (uf && !en[3]);
    if ((of && en[2]) || (uf && en[3])) ix = 1'b0;
    e = {ix, uf, of, ev[1], ev[0]};
    return {e & en, e & ~en};
  endfunction

  function automatic logic [31:0] model_word();
    return {8'h81, 3'b000, m_en, 3'b000, m_ctrl, 3'b000, m_flag};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit we, input logic [31:0] wd, input bit v,
                       input logic [4:0] ev, input bit t, input bit l, input string tag);
    logic [9:0] r;
    sw_wr_en = we; sw_wr_data = wd;
    exc_valid = v; exc_event = ev; exc_tiny = t; exc_acc_loss = l;
    r = expect_split(m_en, ev, t, l);
    if (!v) r = '0;
    m_trap = r[9:5];
    m_flag = (we ? wd[4:0] : m_flag) | r[4:0];
    if (we) begin
      m_en = wd[20:16];
      m_ctrl = wd[12:8];
    end
    @(posedge clk);
    @(negedge clk);
    sw_wr_en = 1'b0; exc_valid = 1'b0;
    chk({tag, " word"}, sw_rd_data, model_word());
    chk({tag, " trap"}, {26'd0, trap_req, trap_cause}, {26'd0, (m_trap != 0), m_trap});
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R4: trap outputs cleared in reset; R1/R2 fixed bits
    chk("R4 trap in reset", {27'd0, trap_req, trap_cause}, 32'd0);
    chk("R1 R2 fixed bits", sw_rd_data & 32'hFFE0E0E0, 32'h81000000);
    rst_n = 1'b1;
    m_en = 0; m_ctrl = 0; m_flag = 0; m_trap = 0;
    cycle(1, 32'h0, 0, 0, 0, 0, "R3 clear");
    // R1 R2 R3: all ones written
    cycle(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1 R2 R3 ones");
    cycle(1, 32'h0015_0A0A, 0, 0, 0, 0, "R3 pattern");
    // R4: reset does not clear fields
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R4 fields kept", sw_rd_data, model_word());
    cycle(1, 32'h0, 0, 0, 0, 0, "R3 clear2");
    // R5 flag path and trap path
    cycle(0, 0, 1, 5'b00001, 0, 0, "R5 io flag");
    cycle(1, 32'h0001_0000, 0, 0, 0, 0, "R5 set io en");
    cycle(0, 0, 1, 5'b00001, 0, 0, "R5 io trap");
    // R7: UF trap on tininess alone
    cycle(1, 32'h0008_0000, 0, 0, 0, 0, "R7 uf en");
    cycle(0, 0, 1, 5'b01000, 1, 0, "R7 uf tiny trap");
    // R8: UF disabled
    cycle(1, 32'h0, 0, 0, 0, 0, "R8 clr");
    cycle(0, 0, 1, 5'b01000, 1, 0, "R8 tiny no loss");
    cycle(0, 0, 1, 5'b01000, 1, 1, "R8 tiny loss");
    // R9: OF disabled raises inexact
    cycle(1, 32'h0, 0, 0, 0, 0, "R9 clr");
    cycle(0, 0, 1, 5'b00100, 0, 0, "R9 of ix");
    // R10: OF trap drops inexact
    cycle(1, 32'h0014_0000, 0, 0, 0, 0, "R10 en");
    cycle(0, 0, 1, 5'b10100, 0, 0, "R10 of trap");
    cycle(1, 32'h0008_0000, 0, 0, 0, 0, "R10 uf en");
    cycle(0, 0, 1, 5'b11000, 1, 1, "R10 uf trap");
    // R11: write and report together; old enables decide
    cycle(1, 32'h0, 0, 0, 0, 0, "R11 clr");
    cycle(1, 32'h0003_0004, 1, 5'b00011, 0, 0, "R11 same edge");
    // R12: valid low ignores events
    cycle(0, 0, 0, 5'b11111, 1, 1, "R12 idle");
    // R6: flags survive idle cycles and reports
    cycle(0, 0, 0, 0, 0, 0, "R6 idle");
    cycle(0, 0, 1, 5'b00010, 0, 0, "R6 trap keeps flags");
    for (int i = 0; i < 600; i++) begin
      cycle(($urandom % 5) == 0, $urandom, ($urandom % 3) != 0, 5'($urandom),
            1'($urandom), 1'($urandom), "R5 R6 R7 R8 R9 R10 R11 R12 random");
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule